// File: doc/BRIEF.md
# Protection Region Configuration Register Bank

This block is the software-visible setup store for a memory protection checker. It sits on a simple word-wide register bus and keeps several groups of registers. Each protection region has a base-address word and an attribute/size word. The bank also has a region-select register, a global control register and a read-only capability word. Every region's stored settings are driven onto wide parallel outputs, together with the three global control flags. A separate access checker reads them from there. The checking, fault signalling and any cache behaviour belong to other blocks.

Software picks a region through the select register and then reads or writes that region's base and attribute words. A faster path also exists. A base write with its valid flag set loads the select register from the region number carried in the low bits of the same word. In that one write the base lands in the named region. Three further pairs of alias offsets reach the same base and attribute words as the primary pair. A loader can therefore stream several regions through consecutive addresses.

Byte offsets are decoded on word boundaries, and the low two address bits are ignored. The offsets are:
- 0x00: capability
- 0x04: control
- 0x08: select
- 0x0C and 0x10: base and attribute
- 0x14/0x18, 0x1C/0x20 and 0x24/0x28: the alias pairs

Any other offset is unmapped.

Top module: `prot_region_regs`

## Requirements
- R1: After reset every register reads zero, except the capability word. The control outputs are low and every region's base and attribute outputs are zero.
- R2: The capability word at 0x00 reads NUM_REGIONS in bits 15:8 and zero in all other bits. Writes to it have no effect.
- R3: The control word at 0x04 holds unit enable in bit 0, handler checking in bit 1 and privileged background map in bit 2. These bits drive unit_enable, unit_handler_check and unit_priv_background. Bits 31:3 read zero.
- R4: The select word at 0x08 is 8 bits wide in bits 7:0, and bits 31:8 read zero. It changes only on a write to 0x08 or on a base write with bit 4 set.
- R5: A base write with bit 4 clear stores bits 31:5 as the base of the currently selected region. Bits 4:0 of the data are not stored, and the select word is unchanged.
- R6: A base write with bit 4 set loads the select word with the zero-extended bits 3:0 of the data. Bits 31:5 go to that region's base in the same write.
- R7: A base read returns the selected region's base in bits 31:5, zero in bit 4 and select bits 3:0 in bits 3:0.
- R8: The attribute word keeps execute-never in bit 28, permission in 26:24, type extension in 21:19, shareable in 18, cacheable in 17, bufferable in 16, subregion disables in 15:8, size in 5:1 and region enable in 0. Bits 31:29, 27, 23:22 and 7:6 read zero and ignore writes, so writable mask 0x173FFF3F.
- R9: Offsets 0x14, 0x1C and 0x24 behave exactly as the base word at 0x0C. Offsets 0x18, 0x20 and 0x28 behave exactly as the attribute word at 0x10.
- R10: While the select word is NUM_REGIONS or more, base and attribute writes change no region. Attribute reads return zero, and base reads return only the select bits 3:0.
- R11: Read data is registered. bus_rdata changes on the clock edge that samples bus_re, and it holds while bus_re is low. Unmapped offsets read zero and ignore writes.
- R12: Region writes reach rgn_base_o (27 bits per region, region r at bits r*27 and up) and rgn_attr_o (32 bits per region, region r at bits r*32 and up) on the clock edge of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| unit_enable | output | 1 | Global protection enable |
| unit_handler_check | output | 1 | Apply regions during fault handlers |
| unit_priv_background | output | 1 | Default map as privileged background |
| rgn_base_o | output | NUM_REGIONS*27 | All region base addresses, bits 31:5 each |
| rgn_attr_o | output | NUM_REGIONS*32 | All region attribute/size words |

## Verification
The assertions assume that bus_we and bus_re are never both high in the same cycle on the same offset. They also assume that the address and write data are stable across the sampling edge. The directed tasks drive each strobe for exactly one cycle and change inputs only on the falling edge. The strobes are never overlapped. The select value is pushed past NUM_REGIONS deliberately, both through the select word and through the valid-flag path. This exercises the ignored-write cases, since the properties place no limit on that value.

// File: rtl/prr_pkg.sv
package prr_pkg;
    localparam int DATA_W   = 32;
    localparam int BASE_LSB = 5;
    localparam int BASE_W   = DATA_W - BASE_LSB;
    localparam int SEL_W    = 8;
    localparam int CTL_W    = 3;

    // word indices of the primary registers; alias pairs follow the base/attr pair
    localparam int unsigned IDX_CAP   = 0;
    localparam int unsigned IDX_CTL   = 1;
    localparam int unsigned IDX_SEL   = 2;
    localparam int unsigned IDX_PAIR0 = 3;

    // bits of the attribute word that hold state; the rest are reserved
    localparam logic [DATA_W-1:0] ATTR_KEEP = 32'h173F_FF3F;

    typedef enum logic [2:0] {
        K_NONE,
        K_CAP,
        K_CTL,
        K_SEL,
        K_BASE,
        K_ATTR
    } reg_kind_e;
endpackage

// File: rtl/prr_decode.sv
module prr_decode
    import prr_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int NUM_ALIASES = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind
);
    localparam int unsigned PAIR_END = IDX_PAIR0 + 2 * (NUM_ALIASES + 1);

    int unsigned idx;

    always_comb begin
        idx  = 32'(addr[ADDR_W-1:2]);
        kind = K_NONE;
        if (idx == IDX_CAP) begin
            kind = K_CAP;
        end else if (idx == IDX_CTL) begin
            kind = K_CTL;
        end else if (idx == IDX_SEL) begin
            kind = K_SEL;
        end else if (idx < PAIR_END) begin
            kind = (((idx - IDX_PAIR0) % 2) == 0) ? K_BASE : K_ATTR;
        end
    end
endmodule

// File: rtl/prr_ctl_regs.sv
module prr_ctl_regs
    import prr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             sel_we,
    input  logic             base_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [CTL_W-1:0] ctl_q,
    output logic [SEL_W-1:0] sel_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_we) begin
            ctl_q <= wdata[CTL_W-1:0];
        end
    end

    // a base write carrying the valid flag re-targets the select word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (sel_we) begin
            sel_q <= wdata[SEL_W-1:0];
        end else if (base_we && wdata[4]) begin
            sel_q <= {{(SEL_W-4){1'b0}}, wdata[3:0]};
        end
    end
endmodule

// File: rtl/prr_region_store.sv
module prr_region_store
    import prr_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SEL_W-1:0]              sel,
    input  logic                          base_we,
    input  logic                          attr_we,
    input  logic [DATA_W-1:0]             wdata,
    output logic [NUM_REGIONS*BASE_W-1:0] base_flat,
    output logic [NUM_REGIONS*DATA_W-1:0] attr_flat,
    output logic [BASE_W-1:0]             rd_base,
    output logic [DATA_W-1:0]             rd_attr
);
    logic [SEL_W-1:0] base_tgt;

    always_comb begin
        base_tgt = wdata[4] ? {{(SEL_W-4){1'b0}}, wdata[3:0]} : sel;
    end

    logic [BASE_W-1:0] base_q [NUM_REGIONS];
    logic [DATA_W-1:0] attr_q [NUM_REGIONS];

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[r] <= '0;
            end else if (base_we && (base_tgt == SEL_W'(r))) begin
                base_q[r] <= wdata[DATA_W-1:BASE_LSB];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                attr_q[r] <= '0;
            end else if (attr_we && (sel == SEL_W'(r))) begin
                attr_q[r] <= wdata & ATTR_KEEP;
            end
        end

        assign base_flat[r*BASE_W +: BASE_W] = base_q[r];
        assign attr_flat[r*DATA_W +: DATA_W] = attr_q[r];
    end

    always_comb begin
        rd_base = '0;
        rd_attr = '0;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (sel == SEL_W'(r)) begin
                rd_base = base_q[r];
                rd_attr = attr_q[r];
            end
        end
    end
endmodule

// File: rtl/prot_region_regs.sv
module prot_region_regs
    import prr_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 6,
    parameter int NUM_ALIASES = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [31:0]                   bus_wdata,
    input  logic                          bus_we,
    input  logic                          bus_re,
    output logic [31:0]                   bus_rdata,
    output logic                          unit_enable,
    output logic                          unit_handler_check,
    output logic                          unit_priv_background,
    output logic [NUM_REGIONS*27-1:0]     rgn_base_o,
    output logic [NUM_REGIONS*32-1:0]     rgn_attr_o
);
    localparam logic [7:0] CAP_COUNT = 8'(NUM_REGIONS);

    reg_kind_e         kind;
    logic [CTL_W-1:0]  ctl_q;
    logic [SEL_W-1:0]  sel_q;
    logic [BASE_W-1:0] rd_base;
    logic [DATA_W-1:0] rd_attr;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rdata_q;

    prr_decode #(
        .ADDR_W      (ADDR_W),
        .NUM_ALIASES (NUM_ALIASES)
    ) dec_i (
        .addr (bus_addr),
        .kind (kind)
    );

    prr_ctl_regs ctl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_we  (bus_we && (kind == K_CTL)),
        .sel_we  (bus_we && (kind == K_SEL)),
        .base_we (bus_we && (kind == K_BASE)),
        .wdata   (bus_wdata),
        .ctl_q   (ctl_q),
        .sel_q   (sel_q)
    );

    prr_region_store #(
        .NUM_REGIONS (NUM_REGIONS)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel_q),
        .base_we   (bus_we && (kind == K_BASE)),
        .attr_we   (bus_we && (kind == K_ATTR)),
        .wdata     (bus_wdata),
        .base_flat (rgn_base_o),
        .attr_flat (rgn_attr_o),
        .rd_base   (rd_base),
        .rd_attr   (rd_attr)
    );

    always_comb begin
        unique case (kind)
            K_CAP:   rd_next = {16'h0000, CAP_COUNT, 8'h00};
            K_CTL:   rd_next = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
            K_SEL:   rd_next = {{(DATA_W-SEL_W){1'b0}}, sel_q};
            K_BASE:  rd_next = {rd_base, 1'b0, sel_q[3:0]};
            K_ATTR:  rd_next = rd_attr;
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_re) begin
            rdata_q <= rd_next;
        end
    end

    assign bus_rdata            = rdata_q;
    assign unit_enable          = ctl_q[0];
    assign unit_handler_check   = ctl_q[1];
    assign unit_priv_background = ctl_q[2];
endmodule

// File: rtl/prr_checker.sv
module prr_checker #(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_we,
    input logic              bus_re,
    input logic [31:0]       bus_rdata,
    input logic              unit_enable,
    input logic              unit_handler_check,
    input logic              unit_priv_background,
    input logic [7:0]        sel_q
);
    logic [ADDR_W-3:0] widx;
    logic              at_cap, at_ctl, at_sel, at_base;

    assign widx    = bus_addr[ADDR_W-1:2];
    assign at_cap  = (widx == 0);
    assign at_ctl  = (widx == 1);
    assign at_sel  = (widx == 2);
    assign at_base = (widx == 3) || (widx == 5) || (widx == 7) || (widx == 9);

    // R2
    p_cap_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && at_cap) |=> (bus_rdata == (32'(NUM_REGIONS) << 8)));

    // R3
    p_ctl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && at_ctl) |=> $stable({unit_enable, unit_handler_check, unit_priv_background}));

    p_ctl_resv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && at_ctl) |=> (bus_rdata[31:3] == 29'h0));

    // R4
    p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (at_sel || (at_base && bus_wdata[4]))) |=> $stable(sel_q));

    // R6
    p_sel_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && at_base && bus_wdata[4]) |=> (sel_q == {4'h0, $past(bus_wdata[3:0])}));

    // R11
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));
endmodule

bind prot_region_regs prr_checker #(
    .NUM_REGIONS (NUM_REGIONS),
    .ADDR_W      (ADDR_W)
) chk_i (
    .clk                  (clk),
    .rst_n                (rst_n),
    .bus_addr             (bus_addr),
    .bus_wdata            (bus_wdata),
    .bus_we               (bus_we),
    .bus_re               (bus_re),
    .bus_rdata            (bus_rdata),
    .unit_enable          (unit_enable),
    .unit_handler_check   (unit_handler_check),
    .unit_priv_background (unit_priv_background),
    .sel_q                (sel_q)
);

// File: tb/prot_region_regs_tb_top.sv
`timescale 1ns/1ps
module prot_region_regs_tb_top;
    localparam int NR = 8;
    localparam int AW = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic              bus_re = 1'b0;
    logic [31:0]       bus_rdata;
    logic              unit_enable, unit_handler_check, unit_priv_background;
    logic [NR*27-1:0]  rgn_base_o;
    logic [NR*32-1:0]  rgn_attr_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    prot_region_regs #(.NUM_REGIONS(NR), .ADDR_W(AW), .NUM_ALIASES(3)) dut_i (
        .clk                  (clk),
        .rst_n                (rst_n),
        .bus_addr             (bus_addr),
        .bus_wdata            (bus_wdata),
        .bus_we               (bus_we),
        .bus_re               (bus_re),
        .bus_rdata            (bus_rdata),
        .unit_enable          (unit_enable),
        .unit_handler_check   (unit_handler_check),
        .unit_priv_background (unit_priv_background),
        .rgn_base_o           (rgn_base_o),
        .rgn_attr_o           (rgn_attr_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] base_of(input int r);
        return {rgn_base_o[r*27 +: 27], 5'b0};
    endfunction

    function automatic logic [31:0] attr_of(input int r);
        return rgn_attr_o[r*32 +: 32];
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        check("R1 control outputs", {29'b0, unit_priv_background, unit_handler_check, unit_enable}, 32'h0);
        check("R1 base outputs", 32'(|rgn_base_o), 32'h0);
        check("R1 attr outputs", 32'(|rgn_attr_o), 32'h0);
        rd(6'h04, d); check("R1 control word", d, 32'h0);
        rd(6'h08, d); check("R1 select word", d, 32'h0);
        rd(6'h10, d); check("R1 attr word", d, 32'h0);
    endtask

    task automatic t_capability();
        logic [31:0] d;
        rd(6'h00, d); check("R2 capability", d, 32'h0000_0800);
        wr(6'h00, 32'hFFFF_FFFF);
        rd(6'h00, d); check("R2 capability after write", d, 32'h0000_0800);
    endtask

    task automatic t_control();
        logic [31:0] d;
        wr(6'h04, 32'hFFFF_FFFF);
        rd(6'h04, d); check("R3 control reserved", d, 32'h7);
        check("R3 control outputs all", {29'b0, unit_priv_background, unit_handler_check, unit_enable}, 32'h7);
        wr(6'h04, 32'h0000_0005);
        check("R3 control outputs 5", {29'b0, unit_priv_background, unit_handler_check, unit_enable}, 32'h5);
    endtask

    task automatic t_select();
        logic [31:0] d;
        wr(6'h08, 32'h1234_5603);
        rd(6'h08, d); check("R4 select width", d, 32'h3);
    endtask

    task automatic t_base_plain();
        logic [31:0] d;
        wr(6'h0C, 32'h2000_00EF);
        check("R5 base of region 3", base_of(3), 32'h2000_00E0);
        rd(6'h08, d); check("R5 select unchanged", d, 32'h3);
        rd(6'h0C, d); check("R7 base read", d, 32'h2000_00E3);
    endtask

    task automatic t_base_valid();
        logic [31:0] d;
        wr(6'h0C, 32'h4002_0015);
        check("R12 base out same edge region 5", base_of(5), 32'h4002_0000);
        check("R6 region 3 untouched", base_of(3), 32'h2000_00E0);
        rd(6'h08, d); check("R6 select loaded", d, 32'h5);
        rd(6'h0C, d); check("R7 base read valid bit zero", d, 32'h4002_0005);
    endtask

    task automatic t_attr();
        logic [31:0] d;
        wr(6'h10, 32'hFFFF_FFFF);
        rd(6'h10, d); check("R8 attr reserved", d, 32'h173F_FF3F);
        check("R12 attr out region 5", attr_of(5), 32'h173F_FF3F);
        wr(6'h10, 32'hE8C0_00C3);
        rd(6'h10, d); check("R8 attr mixed", d, 32'h0000_0003);
    endtask

    task automatic t_alias();
        logic [31:0] d;
        wr(6'h1C, 32'h0800_0011);
        rd(6'h08, d); check("R9 alias2 base sets select", d, 32'h1);
        rd(6'h0C, d); check("R9 alias base via primary", d, 32'h0800_0001);
        rd(6'h24, d); check("R9 alias3 base read", d, 32'h0800_0001);
        wr(6'h18, 32'h0306_0027);
        rd(6'h10, d); check("R9 alias1 attr via primary", d, 32'h0306_0027);
        rd(6'h28, d); check("R9 alias3 attr read", d, 32'h0306_0027);
        check("R9 alias attr reaches region 1", attr_of(1), 32'h0306_0027);
    endtask

    task automatic t_out_of_range();
        logic [31:0]      d;
        logic [NR*27-1:0] b0;
        logic [NR*32-1:0] a0;
        b0 = rgn_base_o; a0 = rgn_attr_o;
        wr(6'h0C, 32'h1000_001C);
        rd(6'h08, d); check("R10 select 12", d, 32'hC);
        rd(6'h0C, d); check("R10 base read out of range", d, 32'h0000_000C);
        wr(6'h10, 32'h0000_0001);
        rd(6'h10, d); check("R10 attr read out of range", d, 32'h0);
        wr(6'h08, 32'h0000_00C8);
        wr(6'h0C, 32'hABCD_E000);
        rd(6'h0C, d); check("R10 base read select 200", d, 32'h0000_0008);
        check("R10 bases untouched", 32'(rgn_base_o != b0), 32'h0);
        check("R10 attrs untouched", 32'(rgn_attr_o != a0), 32'h0);
    endtask

    task automatic t_read_path();
        logic [31:0]      d;
        logic [NR*27-1:0] b0;
        logic [NR*32-1:0] a0;
        rd(6'h04, d); check("R11 control read", d, 32'h5);
        @(negedge clk);
        bus_addr = 6'h00;
        @(negedge clk);
        check("R11 rdata holds without strobe", bus_rdata, 32'h5);
        bus_re = 1'b1;
        #1;
        check("R11 rdata not before edge", bus_rdata, 32'h5);
        @(negedge clk);
        bus_re = 1'b0;
        check("R11 rdata after edge", bus_rdata, 32'h0000_0800);
        b0 = rgn_base_o; a0 = rgn_attr_o;
        wr(6'h2C, 32'hFFFF_FFFF);
        wr(6'h30, 32'hFFFF_FFFF);
        rd(6'h2C, d); check("R11 unmapped read", d, 32'h0);
        check("R11 unmapped write bases", 32'(rgn_base_o != b0), 32'h0);
        check("R11 unmapped write attrs", 32'(rgn_attr_o != a0), 32'h0);
        rd(6'h04, d); check("R11 unmapped write control", d, 32'h5);
        rd(6'h08, d); check("R11 unmapped write select", d, 32'hC8);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_capability();
        t_control();
        t_select();
        t_base_plain();
        t_base_valid();
        t_attr();
        t_alias();
        t_out_of_range();
        t_read_path();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule